// File: doc/BRIEF.md
# Multiple-Time-Programmable Byte Memory Model

This block is a synthesizable, cycle-based stand-in for an electrically erasable byte-wide memory. It is meant to sit under a programming controller in a test environment so that the controller's program, verify, erase and identify sequences can be exercised without any vendor simulation model. The memory holds `2**ADDR_W` bytes. A 16-bit address gives the full 64K x 8 size. The default is a smaller array, so that elaboration stays light.

The control inputs are decoded every clock into one operating mode. The inputs are an active-low select, an active-low read-gate, a flag for high programming voltage on the shared gate pin, and a flag for high voltage on address line 9. Programming ANDs the input byte into the stored byte, so it can only turn ones into zeros. Chip erase is started by entering the erase condition. It runs for a configurable number of cycles, which stands in for half a second, and it sweeps the array back to all ones. A fault input lets a bench make one erase leave bit 0 of every byte untouched. The identify condition returns fixed maker and part bytes, chosen by address bit 0. The output bus is modelled as a data vector plus a drive-enable, and read data appears a fixed `READ_LAT` cycles after the inputs are sampled.

Top module: `mtp_byte_array`

## Requirements
- R1: After reset, `rd_drive` is 0 and no erase is in progress.
- R2: With `chip_sel_n`=0, `out_en_n`=0, `prog_hv`=0 and `addr_hv`=0, the read mode applies. Exactly `READ_LAT` rising edges after the inputs are sampled, `rd_drive` is 1 and `rd_data` holds the byte stored at `addr`. Addresses presented on consecutive cycles come out on consecutive cycles.
- R3: With `chip_sel_n`=0, `prog_hv`=0 and `out_en_n`=1, the outputs are released: `rd_drive` is 0. This holds whatever the value of `addr_hv`.
- R4: With `chip_sel_n`=1, `rd_drive` is 0 whatever the values of `out_en_n`, `prog_hv` and `addr_hv`. In this state no stored byte changes, even when `prog_hv`=1.
- R5: With `chip_sel_n`=0, `prog_hv`=1 and `addr_hv`=0, each clock in which no erase is running replaces the byte at `addr` with (stored AND `wr_data`). Bits can only go from 1 to 0, and a byte of all ones written over stored data leaves that data unchanged.
- R6: When the inputs go from any other mode into `chip_sel_n`=0, `prog_hv`=1, `addr_hv`=1, an erase starts on that edge. It lasts `max(ERASE_CYCLES, 2**ADDR_W)` cycles. After that, every byte reads 8'hFF.
- R7: While an erase runs, program requests are ignored and `rd_drive` stays 0 even with the read inputs applied.
- R8: If `erase_fault` is 1 on the edge that starts an erase, that erase sets bits 7..1 of every byte and leaves bit 0 at its prior value.
- R9: With `chip_sel_n`=0, `out_en_n`=0, `prog_hv`=0 and `addr_hv`=1, the outputs drive an identifier byte after `READ_LAT` edges. The byte is 8'hC2 when `addr[0]`=0 and 8'hD1 when `addr[0]`=1.
- R10: An erase starts only on entry into the erase condition. Holding the erase inputs past the end of an erase does not start another one, so a program that directly follows takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Active-low select; high means standby or program inhibit |
| out_en_n | input | 1 | Active-low read gate (logic level of the shared pin) |
| prog_hv | input | 1 | Programming voltage present on the shared gate pin |
| addr_hv | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Byte to program |
| erase_fault | input | 1 | Makes the erase started on this edge leave bit 0 untouched |
| rd_data | output | 8 | Read or identifier byte |
| rd_drive | output | 1 | Drive-enable for the output bus; 0 means high impedance |

## Verification
The bench builds the block with `ADDR_W`=6, `ERASE_CYCLES`=100 and `READ_LAT`=2. With 64 bytes, every location can be streamed back after each erase, program pass and faulted erase, and compared with a byte-level reference. Setting the erase length above the depth tests the idle tail after the sweep, as well as the sweep itself. A latency of two exposes any off-by-one in the output pipeline during back-to-back reads.

// File: rtl/mtp_pkg.sv
`timescale 1ns/1ps
package mtp_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] ID_MAKER = 8'hC2;
    localparam logic [DATA_W-1:0] ID_PART  = 8'hD1;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUTOFF,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_ERASE
    } mtp_mode_e;

    typedef struct packed {
        logic sel_n;
        logic gate_n;
        logic gate_hv;
        logic a9_hv;
    } mtp_ctrl_t;

    // Mode decode; select dominates, then high voltage on the gate pin.
    function automatic mtp_mode_e decode_mode(input mtp_ctrl_t c);
        mtp_mode_e m;
        if (c.sel_n)        m = MD_STANDBY;
        else if (c.gate_hv) m = c.a9_hv ? MD_ERASE : MD_PROGRAM;
        else if (c.gate_n)  m = MD_OUTOFF;
        else if (c.a9_hv)   m = MD_IDENT;
        else                m = MD_READ;
        return m;
    endfunction

    // Bits OR-ed into a byte by an erase; a faulted erase spares bit 0.
    function automatic logic [DATA_W-1:0] erase_mask(input logic fault);
        return fault ? {{(DATA_W-1){1'b1}}, 1'b0} : {DATA_W{1'b1}};
    endfunction

endpackage

// File: rtl/mtp_mode_decode.sv
`timescale 1ns/1ps
module mtp_mode_decode
    import mtp_pkg::*;
(
    input  mtp_ctrl_t ctrl,
    output mtp_mode_e mode
);
    always_comb mode = decode_mode(ctrl);
endmodule

// File: rtl/mtp_erase_seq.sv
`timescale 1ns/1ps
module mtp_erase_seq
    import mtp_pkg::*;
#(
    parameter int AW           = 6,
    parameter int ERASE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_cond,
    input  logic              fault_in,
    output logic              busy,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [DATA_W-1:0] wmask
);
    localparam int DEPTH = 1 << AW;
    localparam int EFF   = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;
    localparam int CW    = $clog2(EFF + 1);

    logic [CW-1:0] cnt;
    logic          cond_q;
    logic          fault_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cond_q  <= 1'b0;
            fault_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            cond_q <= erase_cond;
            if (busy_q) begin
                if (cnt == CW'(EFF - 1)) begin
                    busy_q <= 1'b0;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (erase_cond && !cond_q) begin
                busy_q  <= 1'b1;
                cnt     <= '0;
                fault_q <= fault_in;
            end
        end
    end

    assign busy  = busy_q;
    assign we    = busy_q && (cnt < CW'(DEPTH));
    assign waddr = cnt[AW-1:0];
    assign wmask = erase_mask(fault_q);
endmodule

// File: rtl/mtp_cell_array.sv
`timescale 1ns/1ps
module mtp_cell_array
    import mtp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              ers_we,
    input  logic [AW-1:0]     ers_addr,
    input  logic [DATA_W-1:0] ers_mask,
    input  logic              prg_we,
    input  logic [AW-1:0]     prg_addr,
    input  logic [DATA_W-1:0] prg_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    // Non-volatile contents: deliberately not touched by reset.
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (ers_we)
            cells[ers_addr] <= cells[ers_addr] | ers_mask;
        else if (prg_we)
            cells[prg_addr] <= cells[prg_addr] & prg_data;
        rd_q <= cells[rd_addr];
    end
endmodule

// File: rtl/mtp_out_pipe.sv
`timescale 1ns/1ps
module mtp_out_pipe
    import mtp_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_drive,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_drive,
    output logic [DATA_W-1:0] out_data
);
    logic [STAGES-1:0] drv_r;
    logic [DATA_W-1:0] dat_r [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_r <= '0;
            for (int i = 0; i < STAGES; i++) dat_r[i] <= '0;
        end else begin
            drv_r[0] <= in_drive;
            dat_r[0] <= in_data;
            for (int i = 1; i < STAGES; i++) begin
                drv_r[i] <= drv_r[i-1];
                dat_r[i] <= dat_r[i-1];
            end
        end
    end

    assign out_drive = drv_r[STAGES-1];
    assign out_data  = dat_r[STAGES-1];
endmodule

// File: rtl/mtp_byte_array.sv
`timescale 1ns/1ps
module mtp_byte_array
    import mtp_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int ERASE_CYCLES = 2000,
    parameter int READ_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              prog_hv,
    input  logic              addr_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_fault,
    output logic [7:0]        rd_data,
    output logic              rd_drive
);
    localparam int EXTRA = READ_LAT - 1;

    mtp_ctrl_t ctrl;
    mtp_mode_e mode;

    assign ctrl = '{sel_n: chip_sel_n, gate_n: out_en_n, gate_hv: prog_hv, a9_hv: addr_hv};

    mtp_mode_decode i_decode (.ctrl(ctrl), .mode(mode));

    logic              ers_busy;
    logic              ers_we;
    logic [ADDR_W-1:0] ers_addr;
    logic [DATA_W-1:0] ers_mask;
    logic              prog_we;
    logic [DATA_W-1:0] cell_q;

    mtp_erase_seq #(.AW(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) i_erase (
        .clk        (clk),
        .rst        (rst),
        .erase_cond (mode == MD_ERASE),
        .fault_in   (erase_fault),
        .busy       (ers_busy),
        .we         (ers_we),
        .waddr      (ers_addr),
        .wmask      (ers_mask)
    );

    assign prog_we = (mode == MD_PROGRAM) && !ers_busy;

    mtp_cell_array #(.AW(ADDR_W)) i_cells (
        .clk      (clk),
        .ers_we   (ers_we),
        .ers_addr (ers_addr),
        .ers_mask (ers_mask),
        .prg_we   (prog_we),
        .prg_addr (addr),
        .prg_data (wr_data),
        .rd_addr  (addr),
        .rd_q     (cell_q)
    );

    // First output stage, aligned with the registered cell read.
    logic drv_s0, ident_s0, idsel_s0;
    logic [DATA_W-1:0] first_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_s0   <= 1'b0;
            ident_s0 <= 1'b0;
            idsel_s0 <= 1'b0;
        end else begin
            drv_s0   <= ((mode == MD_READ) || (mode == MD_IDENT)) && !ers_busy;
            ident_s0 <= (mode == MD_IDENT);
            idsel_s0 <= addr[0];
        end
    end

    always_comb begin
        if (ident_s0) first_data = idsel_s0 ? ID_PART : ID_MAKER;
        else          first_data = cell_q;
    end

    generate
        if (EXTRA == 0) begin : g_direct
            assign rd_drive = drv_s0;
            assign rd_data  = first_data;
        end else begin : g_piped
            mtp_out_pipe #(.STAGES(EXTRA)) i_pipe (
                .clk       (clk),
                .rst       (rst),
                .in_drive  (drv_s0),
                .in_data   (first_data),
                .out_drive (rd_drive),
                .out_data  (rd_data)
            );
        end
    endgenerate
endmodule

// File: rtl/mtp_byte_array_chk.sv
`timescale 1ns/1ps
module mtp_byte_array_chk #(
    parameter int ADDR_W       = 10,
    parameter int ERASE_CYCLES = 2000,
    parameter int READ_LAT     = 2
) (
    input logic clk,
    input logic rst,
    input logic chip_sel_n,
    input logic out_en_n,
    input logic prog_hv,
    input logic addr_hv,
    input logic rd_drive,
    input logic busy,
    input logic prog_we,
    input logic ers_we
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int EFF   = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;

    logic [READ_LAT-1:0] sb_hist;
    logic [READ_LAT-1:0] off_hist;
    int                  busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_hist  <= '0;
            off_hist <= '0;
            busy_len <= 0;
        end else begin
            sb_hist[0]  <= chip_sel_n;
            off_hist[0] <= !chip_sel_n && out_en_n && !prog_hv;
            for (int i = 1; i < READ_LAT; i++) begin
                sb_hist[i]  <= sb_hist[i-1];
                off_hist[i] <= off_hist[i-1];
            end
            busy_len <= busy ? busy_len + 1 : 0;
        end
    end

    p_hiz_standby_r4: assert property (@(posedge clk) disable iff (rst)
        sb_hist[READ_LAT-1] |-> !rd_drive);

    p_hiz_outoff_r3: assert property (@(posedge clk) disable iff (rst)
        off_hist[READ_LAT-1] |-> !rd_drive);

    p_write_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_we, ers_we}));

    p_erase_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == EFF));

    p_erase_entry_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!chip_sel_n && prog_hv && addr_hv));

    p_no_retrigger_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !busy);
endmodule

bind mtp_byte_array mtp_byte_array_chk #(
    .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES), .READ_LAT(READ_LAT)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .prog_hv    (prog_hv),
    .addr_hv    (addr_hv),
    .rd_drive   (rd_drive),
    .busy       (ers_busy),
    .prog_we    (prog_we),
    .ers_we     (ers_we)
);

// File: tb/test_mtp_byte_array.sv
`timescale 1ns/1ps
module test_mtp_byte_array;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int ECYC  = 100;
    localparam int LAT   = 2;
    localparam int EFF   = (ECYC > DEPTH) ? ECYC : DEPTH;

    logic          clk = 1'b0;
    logic          rst;
    logic          chip_sel_n, out_en_n, prog_hv, addr_hv, erase_fault;
    logic [AW-1:0] addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          rd_drive;

    logic [7:0] model [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mtp_byte_array #(.ADDR_W(AW), .ERASE_CYCLES(ECYC), .READ_LAT(LAT)) i_mtp_byte_array (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .prog_hv(prog_hv), .addr_hv(addr_hv), .addr(addr), .wr_data(wr_data),
        .erase_fault(erase_fault), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic pins(input logic s, input logic g, input logic ph, input logic ah,
                        input logic [AW-1:0] a, input logic [7:0] d, input logic f);
        @(posedge clk); #1;
        chip_sel_n = s; out_en_n = g; prog_hv = ph; addr_hv = ah;
        addr = a; wr_data = d; erase_fault = f;
    endtask

    task automatic idle(input int n);
        pins(1, 1, 0, 0, '0, 8'h00, 0);
        repeat (n) @(posedge clk);
    endtask

    task automatic settle();
        repeat (LAT) @(posedge clk);
        #1;
    endtask

    // Back-to-back reads of the whole array, compared against the model.
    task automatic stream_read(input string req);
        for (int j = 0; j < DEPTH + LAT; j++) begin
            pins(0, 0, 0, 0, AW'(j < DEPTH ? j : 0), 8'h00, 0);
            @(negedge clk);
            if (j >= LAT)
                check(rd_drive === 1'b1 && rd_data === model[j-LAT], req,
                      {rd_drive, rd_data}, {1'b1, model[j-LAT]});
        end
        idle(1);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        pins(0, 1, 1, 0, a, d, 0);
        model[a] = model[a] & d;
        idle(1);
    endtask

    task automatic erase_all(input logic fault);
        pins(0, 1, 1, 1, '0, 8'h00, fault);
        idle(EFF + 3);
        for (int i = 0; i < DEPTH; i++)
            model[i] = fault ? (model[i] | 8'hFE) : 8'hFF;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        chip_sel_n = 1; out_en_n = 1; prog_hv = 0; addr_hv = 0;
        addr = '0; wr_data = '0; erase_fault = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1 check(rd_drive === 1'b0, "R1 drive after reset", {8'h0, rd_drive}, 9'h0);
        // R1: no erase running, so a read is driven straight away
        pins(0, 0, 0, 1, '0, 8'h00, 0);
        settle();
        check(rd_drive === 1'b1, "R1 not busy after reset", {8'h0, rd_drive}, 9'h1);
        idle(1);
    endtask

    task automatic t_erase_clean();
        erase_all(0);
        stream_read("R6 erase gives all ones");
    endtask

    task automatic t_program();
        for (int i = 0; i < DEPTH; i++) program_byte(AW'(i), 8'((i * 37) ^ 8'h5A));
        stream_read("R5/R2 programmed pattern");
        program_byte(5, 8'hF0);
        program_byte(9, 8'hFF);
        program_byte(12, 8'h0F);
        pins(0, 0, 0, 0, 5, 8'h00, 0);  settle();
        check(rd_data === model[5], "R5 clear-only on reprogram", {1'b0, rd_data}, {1'b0, model[5]});
        pins(0, 0, 0, 0, 9, 8'h00, 0);  settle();
        check(rd_data === model[9], "R5 all-ones write no change", {1'b0, rd_data}, {1'b0, model[9]});
        pins(0, 0, 0, 0, 12, 8'h00, 0); settle();
        check(rd_data === model[12], "R2 read after reprogram", {1'b0, rd_data}, {1'b0, model[12]});
        idle(1);
    endtask

    task automatic t_outoff();
        pins(0, 1, 0, 0, 3, 8'h00, 0); settle();
        check(rd_drive === 1'b0, "R3 output disable", {8'h0, rd_drive}, 9'h0);
        pins(0, 1, 0, 1, 3, 8'h00, 0); settle();
        check(rd_drive === 1'b0, "R3 output disable with a9 hv", {8'h0, rd_drive}, 9'h0);
        idle(1);
    endtask

    task automatic t_standby();
        pins(1, 0, 0, 0, 7, 8'h00, 0); settle();
        check(rd_drive === 1'b0, "R4 standby with gate low", {8'h0, rd_drive}, 9'h0);
        pins(1, 0, 1, 1, 7, 8'h00, 0);
        repeat (3) @(posedge clk);
        #1 check(rd_drive === 1'b0, "R4 inhibit hv hiz", {8'h0, rd_drive}, 9'h0);
        pins(0, 0, 0, 0, 7, 8'h00, 0); settle();
        check(rd_data === model[7], "R4 inhibit keeps data", {1'b0, rd_data}, {1'b0, model[7]});
        idle(1);
    endtask

    task automatic t_ident();
        pins(0, 0, 0, 1, 0, 8'h00, 0); settle();
        check(rd_drive === 1'b1 && rd_data === 8'hC2, "R9 maker byte", {rd_drive, rd_data}, 9'h1C2);
        pins(0, 0, 0, 1, 1, 8'h00, 0); settle();
        check(rd_drive === 1'b1 && rd_data === 8'hD1, "R9 part byte", {rd_drive, rd_data}, 9'h1D1);
        pins(0, 0, 0, 1, AW'(6), 8'h00, 0); settle();
        check(rd_data === 8'hC2, "R9 only bit 0 selects", {1'b0, rd_data}, 9'h0C2);
        idle(1);
    endtask

    task automatic t_busy();
        pins(0, 1, 1, 1, '0, 8'h00, 0);
        idle(6);
        pins(0, 1, 1, 0, 1, 8'h00, 0);
        repeat (2) @(posedge clk);
        pins(0, 0, 0, 0, 1, 8'h00, 0); settle();
        check(rd_drive === 1'b0, "R7 no drive during erase", {8'h0, rd_drive}, 9'h0);
        idle(EFF + 3);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        pins(0, 0, 0, 0, 1, 8'h00, 0); settle();
        check(rd_data === 8'hFF, "R7 program ignored while busy", {1'b0, rd_data}, 9'h0FF);
        idle(1);
    endtask

    task automatic t_retrigger();
        pins(0, 1, 1, 1, '0, 8'h00, 0);
        repeat (EFF + 6) @(posedge clk);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        pins(0, 1, 1, 0, 2, 8'h00, 0);
        model[2] = 8'h00;
        pins(0, 0, 0, 0, 2, 8'h00, 0); settle();
        check(rd_data === 8'h00, "R10 no second erase", {1'b0, rd_data}, 9'h000);
        idle(1);
    endtask

    task automatic t_fault();
        for (int i = 0; i < DEPTH; i++) program_byte(AW'(i), 8'(i * 11));
        erase_all(1);
        stream_read("R8 faulted erase spares bit 0");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_erase_clean();
        t_program();
        t_outoff();
        t_standby();
        t_ident();
        t_busy();
        t_retrigger();
        t_fault();
        finish_run();
    end
endmodule